// File: doc/BRIEF.md
# System Lockup and Intrusion Monitor

This block watches two things for system management. First, it checks that the processor starts running after reset. A watchdog counts core clocks, and the processor must report its first instruction fetch on a strobe. If the window runs out twice with no fetch, the block drives a bus reset pulse of fixed length and then arms the watchdog again. A fetch seen in time disarms the watchdog until the next reset of the block.

Second, it watches a chassis-intrusion switch. The switch input is active low and asynchronous. It passes through a two-flop synchronizer and then a debouncer. The debouncer only moves forward on pulses of a slow real-time-clock tick enable. A debounced intrusion sets a sticky status bit. A two-bit select field routes that bit to a level interrupt request or to a level system-management interrupt. Strobes from the monitored devices set separate activity bits. Software clears every status bit by writing 1 to it.

The watchdog controller has four states: FIRST_WAIT, SECOND_WAIT, RESET_PULSE and DISARMED. Its transitions are:
- expire1: FIRST_WAIT to SECOND_WAIT.
- expire2: SECOND_WAIT to RESET_PULSE.
- rearm: RESET_PULSE to FIRST_WAIT.
- fetch_ok: FIRST_WAIT or SECOND_WAIT to DISARMED.

The debouncer has three states: IDLE, QUALIFY and HELD. Its transitions are:
- seen: IDLE to QUALIFY, when the synchronized input is active.
- confirm: QUALIFY to HELD, on the final tick.
- drop: QUALIFY or HELD to IDLE, when the synchronized input is inactive.

Top module: `sysmon_top`

## Requirements
- R1: After reset, the following are all low: bus reset, IRQ and SMI. Every status and control register reads 0.
- R2: With no fetch strobe, bus reset rises exactly 2*WD_CYCLES core clocks after reset is released. It stays low through the first expiry.
- R3: Bus reset stays high for exactly PULSE_CYCLES cycles (16 by default). The watchdog then re-arms, and without a fetch it pulses again after a further 2*WD_CYCLES cycles.
- R4: A fetch strobe during FIRST_WAIT or SECOND_WAIT disarms the watchdog. Bus reset then stays low until the block's next reset.
- R5: An intrusion counts only after the synchronized input has stayed active across DEB_TICKS tick pulses (2 by default). A shorter assertion, or ticks with no intrusion, leaves the status bit clear.
- R6: A debounced intrusion sets bit 0 of the status register at address 0. The bit stays set after the switch returns to inactive.
- R7: Writing 1 to a status bit clears it. Writing 0 to it has no effect. This holds for bit 0 at address 0 and for the activity bits at address 2.
- R8: The control register is at address 1, and its bits [1:0] are the select field. The codes are: 01 routes the intrusion bit to IRQ, 10 routes it to SMI, and 00 or 11 route it to neither. The control register reads back what was written.
- R9: IRQ and SMI are levels. The routed output is high exactly while the intrusion status bit is set.
- R10: A one-cycle strobe on dev_act[k] sets bit k at address 2. The bit order is: 0 serial port, 1 parallel port, 2 floppy controller, 3 keyboard controller, 4 audio.
- R11: Clearing the intrusion bit while the switch is still held does not set it again. A new assertion that is debounced again is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | AW (2) | Register address: 0 status, 1 control, 2 activity |
| reg_wdata | input | DW (8) | Write data |
| reg_rdata | output | DW (8) | Read data (combinational from reg_addr) |
| rtc_tick | input | 1 | One-cycle real-time-clock tick enable |
| fetch_seen | input | 1 | Strobe: processor fetched its first instruction |
| intrude_n | input | 1 | Raw chassis switch, active low, asynchronous |
| dev_act | input | ACT_W (5) | Device activity strobes |
| smi_out | output | 1 | System-management interrupt level |
| irq_out | output | 1 | Interrupt request level |
| bus_rst_out | output | 1 | Bus reset pulse |

## Verification
A watchdog state that is wrong shows at bus_rst_out at the cycle where the pulse should have risen or fallen. If the pulse is early, late, missing, too short or too long, the output is wrong within one core cycle of the expected edge. A debouncer state that is wrong shows as the intrusion bit at address 0 being set one tick too early, never set, or set again after a clear. Reading the register a few cycles after each tick catches this. A routing or status register that is wrong shows at irq_out or smi_out in the cycle after the write that changes it.

// File: rtl/sysmon_pkg.sv
package sysmon_pkg;

    typedef enum logic [1:0] {
        WD_FIRST_WAIT  = 2'd0,
        WD_SECOND_WAIT = 2'd1,
        WD_RESET_PULSE = 2'd2,
        WD_DISARMED    = 2'd3
    } wd_state_t;

    typedef enum logic [1:0] {
        DB_IDLE    = 2'd0,
        DB_QUALIFY = 2'd1,
        DB_HELD    = 2'd2
    } db_state_t;

    localparam int ACT_W = 5;

    localparam logic [1:0] SEL_NONE = 2'b00;
    localparam logic [1:0] SEL_IRQ  = 2'b01;
    localparam logic [1:0] SEL_SMI  = 2'b10;

    localparam int ADDR_STS  = 0;
    localparam int ADDR_CTRL = 1;
    localparam int ADDR_ACT  = 2;

endpackage

// File: rtl/sysmon_watchdog.sv
module sysmon_watchdog
    import sysmon_pkg::*;
#(
    parameter int WD_CYCLES    = 64,
    parameter int PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_i,
    output logic bus_rst_o
);

    localparam int MAXC = (WD_CYCLES > PULSE_CYCLES) ? WD_CYCLES : PULSE_CYCLES;
    localparam int CW   = $clog2(MAXC) + 1;
    localparam logic [CW-1:0] WD_LAST    = CW'(WD_CYCLES - 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYCLES - 1);

    wd_state_t       state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_FIRST_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        unique case (state_q)
            WD_FIRST_WAIT: begin
                if (fetch_i) begin
                    state_d = WD_DISARMED;
                    cnt_d   = '0;
                end else if (cnt_q == WD_LAST) begin
                    state_d = WD_SECOND_WAIT;
                    cnt_d   = '0;
                end
            end
            WD_SECOND_WAIT: begin
                if (fetch_i) begin
                    state_d = WD_DISARMED;
                    cnt_d   = '0;
                end else if (cnt_q == WD_LAST) begin
                    state_d = WD_RESET_PULSE;
                    cnt_d   = '0;
                end
            end
            WD_RESET_PULSE: begin
                if (cnt_q == PULSE_LAST) begin
                    state_d = WD_FIRST_WAIT;
                    cnt_d   = '0;
                end
            end
            WD_DISARMED: begin
                cnt_d = '0;
            end
            default: begin
                state_d = WD_FIRST_WAIT;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        bus_rst_o = (state_q == WD_RESET_PULSE);
    end

    // Pulse length is measured by a separate counter.
    logic [CW-1:0] chk_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          chk_len_q <= '0;
        else if (bus_rst_o)  chk_len_q <= chk_len_q + 1'b1;
        else                 chk_len_q <= '0;
    end

    p_pulse_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rst_o) |-> (chk_len_q == CW'(PULSE_CYCLES)));

    p_two_expiries_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rst_o) |-> ($past(state_q) == WD_SECOND_WAIT));

    p_disarm_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_DISARMED) |=> (state_q == WD_DISARMED));

    p_fetch_disarms_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && (state_q == WD_FIRST_WAIT || state_q == WD_SECOND_WAIT))
        |=> !bus_rst_o);

endmodule

// File: rtl/sysmon_debounce.sv
module sysmon_debounce
    import sysmon_pkg::*;
#(
    parameter int DEB_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n_i,
    input  logic tick_i,
    output logic detect_o
);

    localparam int TW = $clog2(DEB_TICKS + 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(DEB_TICKS - 1);

    logic [1:0]    sync_q;
    logic          active;
    db_state_t     state_q, state_d;
    logic [TW-1:0] tcnt_q, tcnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], raw_n_i};
    end

    assign active = !sync_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_IDLE;
            tcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            tcnt_q  <= tcnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        tcnt_d  = tcnt_q;
        unique case (state_q)
            DB_IDLE: begin
                tcnt_d = '0;
                if (active) state_d = DB_QUALIFY;
            end
            DB_QUALIFY: begin
                if (!active) begin
                    state_d = DB_IDLE;
                    tcnt_d  = '0;
                end else if (tick_i) begin
                    if (tcnt_q == TICK_LAST) begin
                        state_d = DB_HELD;
                        tcnt_d  = '0;
                    end else begin
                        tcnt_d = tcnt_q + 1'b1;
                    end
                end
            end
            DB_HELD: begin
                if (!active) state_d = DB_IDLE;
            end
            default: begin
                state_d = DB_IDLE;
                tcnt_d  = '0;
            end
        endcase
    end

    always_comb begin
        detect_o = (state_q == DB_QUALIFY) && active && tick_i && (tcnt_q == TICK_LAST);
    end

    p_tick_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        detect_o |-> tick_i);

    p_no_retrigger_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DB_HELD) |-> !detect_o);

    p_detect_needs_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        detect_o |-> !sync_q[1]);

endmodule

// File: rtl/sysmon_regs.sv
module sysmon_regs
    import sysmon_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    input  logic             intr_det_i,
    input  logic [ACT_W-1:0] act_i,
    output logic             irq_o,
    output logic             smi_o
);

    logic             intr_q;
    logic [DW-1:0]    ctrl_q;
    logic [ACT_W-1:0] act_q;
    logic             wr_sts, wr_ctrl, wr_act;
    logic [1:0]       sel;

    assign wr_sts  = wr_en_i && (addr_i == AW'(ADDR_STS));
    assign wr_ctrl = wr_en_i && (addr_i == AW'(ADDR_CTRL));
    assign wr_act  = wr_en_i && (addr_i == AW'(ADDR_ACT));
    assign sel     = ctrl_q[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            intr_q <= 1'b0;
            ctrl_q <= '0;
            act_q  <= '0;
        end else begin
            intr_q <= (intr_q && !(wr_sts && wdata_i[0])) || intr_det_i;
            if (wr_ctrl) ctrl_q <= wdata_i;
            act_q  <= (act_q & ~(wr_act ? wdata_i[ACT_W-1:0] : '0)) | act_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            AW'(ADDR_STS):  rdata_o = DW'(intr_q);
            AW'(ADDR_CTRL): rdata_o = ctrl_q;
            AW'(ADDR_ACT):  rdata_o = DW'(act_q);
            default:        rdata_o = '0;
        endcase
    end

    always_comb begin
        irq_o = intr_q && (sel == SEL_IRQ);
        smi_o = intr_q && (sel == SEL_SMI);
    end

    p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        intr_det_i |=> intr_q);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_q && !(wr_sts && wdata_i[0])) |=> intr_q);

    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && wdata_i[0] && !intr_det_i) |=> !intr_q);

    p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && smi_o));

    p_act_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i != '0) |=> ((act_q & $past(act_i)) == $past(act_i)));

endmodule

// File: rtl/sysmon_top.sv
module sysmon_top
    import sysmon_pkg::*;
#(
    parameter int WD_CYCLES    = 64,
    parameter int PULSE_CYCLES = 16,
    parameter int DEB_TICKS    = 2,
    parameter int AW           = 2,
    parameter int DW           = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             rtc_tick,
    input  logic             fetch_seen,
    input  logic             intrude_n,
    input  logic [ACT_W-1:0] dev_act,
    output logic             smi_out,
    output logic             irq_out,
    output logic             bus_rst_out
);

    logic intr_det;

    sysmon_watchdog #(
        .WD_CYCLES    (WD_CYCLES),
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_wd (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_i   (fetch_seen),
        .bus_rst_o (bus_rst_out)
    );

    sysmon_debounce #(
        .DEB_TICKS (DEB_TICKS)
    ) u_db (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_n_i  (intrude_n),
        .tick_i   (rtc_tick),
        .detect_o (intr_det)
    );

    sysmon_regs #(
        .AW (AW),
        .DW (DW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (reg_wr_en),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .rdata_o    (reg_rdata),
        .intr_det_i (intr_det),
        .act_i      (dev_act),
        .irq_o      (irq_out),
        .smi_o      (smi_out)
    );

endmodule

// File: tb/sysmon_top_test.sv
`timescale 1ns/1ps
module sysmon_top_test;

    localparam int WD    = 64;
    localparam int PULSE = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rtc_tick = 1'b0;
    logic       fetch_seen = 1'b0;
    logic       intrude_n = 1'b1;
    logic [4:0] dev_act = '0;
    logic       smi_out, irq_out, bus_rst_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sysmon_top #(.WD_CYCLES(WD), .PULSE_CYCLES(PULSE)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rtc_tick(rtc_tick),
        .fetch_seen(fetch_seen), .intrude_n(intrude_n), .dev_act(dev_act),
        .smi_out(smi_out), .irq_out(irq_out), .bus_rst_out(bus_rst_out)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_wr_en = 0; rtc_tick = 0; fetch_seen = 0;
        intrude_n = 1'b1; dev_act = '0;
        cyc(2);
        rst_n = 1'b1;
    endtask

    task automatic reg_write(int a, int d);
        reg_addr = a[1:0]; reg_wdata = d[7:0]; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(int a, output int d);
        reg_addr = a[1:0];
        #0.5;
        d = int'(reg_rdata);
    endtask

    task automatic tick();
        rtc_tick = 1'b1;
        @(negedge clk);
        rtc_tick = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        do_reset();
        check("R1 bus_rst", bus_rst_out, 0);
        check("R1 irq", irq_out, 0);
        check("R1 smi", smi_out, 0);
        reg_read(0, v); check("R1 status", v, 0);
        reg_read(1, v); check("R1 control", v, 0);
        reg_read(2, v); check("R1 activity", v, 0);
    endtask

    task automatic t_lockup();
        int bad2 = 0, bad3 = 0;
        do_reset();
        for (int n = 1; n <= 4*WD + 2*PULSE + 4; n++) begin
            @(negedge clk);
            if (n <= 2*WD + PULSE) begin
                if (bus_rst_out != ((n >= 2*WD) && (n < 2*WD + PULSE))) bad2++;
            end else begin
                if (bus_rst_out != ((n >= 4*WD + PULSE) && (n < 4*WD + 2*PULSE))) bad3++;
            end
            if (n == WD + 1) check("R2 low after first expiry", bus_rst_out, 0);
            if (n == 2*WD - 1) check("R2 low before second expiry", bus_rst_out, 0);
            if (n == 2*WD) check("R2 rise after second expiry", bus_rst_out, 1);
            if (n == 2*WD + PULSE - 1) check("R3 last pulse cycle", bus_rst_out, 1);
            if (n == 2*WD + PULSE) check("R3 pulse ended", bus_rst_out, 0);
        end
        check("R2 first pulse timing mismatches", bad2, 0);
        check("R3 rearm second pulse mismatches", bad3, 0);
    endtask

    task automatic t_disarm(int wait_cycles);
        int highs = 0;
        do_reset();
        cyc(wait_cycles);
        fetch_seen = 1'b1;
        @(negedge clk);
        fetch_seen = 1'b0;
        for (int n = 0; n < 6*WD; n++) begin
            @(negedge clk);
            if (bus_rst_out) highs++;
        end
        check("R4 no bus reset after fetch", highs, 0);
    endtask

    task automatic t_intrusion_route();
        int v;
        do_reset();
        reg_write(1, 1);
        intrude_n = 1'b0;
        cyc(4);
        reg_read(0, v); check("R5 no set before ticks", v, 0);
        tick(); cyc(2);
        reg_read(0, v); check("R5 no set after one tick", v, 0);
        check("R9 irq low before detect", irq_out, 0);
        tick(); cyc(2);
        reg_read(0, v); check("R6 set after two ticks", v, 1);
        check("R9 irq follows status", irq_out, 1);
        check("R8 smi not routed for 01", smi_out, 0);
        intrude_n = 1'b1;
        cyc(4); tick(); cyc(2);
        reg_read(0, v); check("R6 sticky after release", v, 1);
        reg_write(0, 0);
        reg_read(0, v); check("R7 write 0 no effect", v, 1);
        reg_write(1, 2);
        check("R8 sel 10 smi", smi_out, 1);
        check("R8 sel 10 irq", irq_out, 0);
        reg_write(1, 3);
        check("R8 sel 11 none", {31'd0, smi_out} + {31'd0, irq_out}, 0);
        reg_write(1, 0);
        check("R8 sel 00 none", {31'd0, smi_out} + {31'd0, irq_out}, 0);
        reg_read(1, v); check("R8 control readback", v, 0);
        reg_write(1, 2);
        reg_write(0, 1);
        reg_read(0, v); check("R7 write 1 clears", v, 0);
        check("R9 smi drops with status", smi_out, 0);
    endtask

    task automatic t_glitch();
        int v;
        do_reset();
        tick(); tick(); tick(); cyc(2);
        reg_read(0, v); check("R5 ticks without intrusion", v, 0);
        intrude_n = 1'b0;
        cyc(4); tick();
        intrude_n = 1'b1;
        cyc(4); tick(); tick(); cyc(2);
        reg_read(0, v); check("R5 short assertion ignored", v, 0);
    endtask

    task automatic t_retrigger();
        int v;
        do_reset();
        intrude_n = 1'b0;
        cyc(4); tick(); tick(); cyc(2);
        reg_read(0, v); check("R11 initial detect", v, 1);
        reg_write(0, 1);
        tick(); tick(); tick(); cyc(2);
        reg_read(0, v); check("R11 no reset while held", v, 0);
        intrude_n = 1'b1;
        cyc(4);
        intrude_n = 1'b0;
        cyc(4); tick(); tick(); cyc(2);
        reg_read(0, v); check("R11 new assertion detected", v, 1);
    endtask

    task automatic t_activity();
        int v;
        int exp = 0;
        do_reset();
        for (int k = 0; k < 5; k++) begin
            dev_act = 5'(1 << k);
            @(negedge clk);
            dev_act = '0;
            exp |= (1 << k);
            reg_read(2, v); check("R10 activity bit set", v, exp);
        end
        reg_write(2, 0);
        reg_read(2, v); check("R7 activity write 0", v, 5'h1f);
        reg_write(2, 4);
        reg_read(2, v); check("R7 activity clear bit 2 only", v, 5'h1b);
        dev_act = 5'b00100;
        reg_write(2, 4);
        dev_act = '0;
        reg_read(2, v); check("R10 set wins over clear", v, 5'h1f);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        t_reset();
        t_lockup();
        t_disarm(10);
        t_disarm(WD + 5);
        t_intrusion_route();
        t_glitch();
        t_retrigger();
        t_activity();
        finish_run();
    end

endmodule